// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

A purely combinational adder that sums two unsigned operands and a carry input. It produces a sum of the operand width and a carry output. The per-bit propagate (a xor b) and generate (a and b) terms feed a balanced binary tree of group combiners.

- The tree builds group terms over 2-bit, 4-bit and wider groups, up to the full word.
- Every carry whose bit index is a multiple of a group size is taken straight from the matching group term and a carry that is already known. No chain runs through all the bits.
- Carries at the remaining positions come from a single local step: generate OR (propagate AND carry).

Every gate in the adder has two inputs. The logic depth therefore grows with the log of the width, not with the width itself.

The block sits inside a datapath as a plain arithmetic unit. It has no clock, no storage and no handshake. Its outputs settle from its inputs. The width is a parameter that must be a power of two, and the default is 8 bits.

Top module: `cla_adder`

## Requirements
- R1: For every value of `a`, `b` and `cin`, the 9-bit value {`cout`, `sum`} equals `a` + `b` + `cin` with the default width W = 8.
- R2: When `a` is zero and `cin` is 0, `sum` equals `b` and `cout` is 0.
- R3: The carry into each bit j (1 ≤ j ≤ W) equals bit j of the sum of the low j bits of `a`, the low j bits of `b`, and `cin`. At the ports, this carry shows as `sum[j]` xor `a[j]` xor `b[j]` for j < W, and as `cout` for j = W.
- R4: When `a` xor `b` is all ones (every bit propagates), `cout` equals `cin` and every bit of `sum` equals the inverse of `cin`.
- R5: When `a` and `b` have no set bit in common and `cin` is 0, `cout` is 0 and `sum` equals `a` or `b`.
- R6: Carries at positions 2, 4 and 8 are formed from group terms and `cin`. The carry at position 6 is formed from the group over bits 4 to 5 and the carry at position 4. The carries at positions 1, 3, 5 and 7 each take one local step from the carry below them. Every gate has two inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bound checker compares the outputs and each internal carry with arithmetic sums on every input change. It relies on the operands and carry input being 2-state values with no unknown or high-impedance bits, and on the width being a power of two. The bench draws every input from one sweep counter, so every input always holds a defined value. That sweep covers all 2^17 combinations at the default width, which includes every full-propagate, disjoint-bit and zero-operand pattern named above.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Number of trailing zero bits of a positive integer.
  function automatic int trail_zeros(input int v);
    int n;
    int x;
    n = 0;
    x = v;
    while ((x > 0) && ((x % 2) == 0)) begin
      x = x / 2;
      n = n + 1;
    end
    return n;
  endfunction

  // First node index of tree level k in the flat node array.
  // Level 0 holds W single-bit nodes, level k holds W>>k nodes.
  function automatic int level_base(input int w, input int k);
    return 2 * w - 2 * (w >> k);
  endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p,
  output logic [W-1:0] g
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign p[i] = a[i] ^ b[i];
    assign g[i] = a[i] & b[i];
  end
endmodule

// File: rtl/cla_pg_merge.sv
module cla_pg_merge (
  input  logic lo_p,
  input  logic lo_g,
  input  logic hi_p,
  input  logic hi_g,
  output logic p,
  output logic g
);
  logic pass_lo;
  assign p       = lo_p & hi_p;
  assign pass_lo = hi_p & lo_g;
  assign g       = hi_g | pass_lo;
endmodule

// File: rtl/cla_carry_step.sv
module cla_carry_step (
  input  logic grp_p,
  input  logic grp_g,
  input  logic ci,
  output logic co
);
  logic pass_ci;
  assign pass_ci = grp_p & ci;
  assign co      = grp_g | pass_ci;
endmodule

// File: rtl/cla_sum.sv
module cla_sum #(
  parameter int W = 8
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] ci,
  output logic [W-1:0] s
);
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign s[i] = p[i] ^ ci[i];
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  import cla_pkg::*;

  localparam int LEVELS = $clog2(W);
  localparam int NODES  = 2 * W - 1;

  // Flat tree: level 0 nodes are single bits, the last node spans the word.
  logic [NODES-1:0] grp_p;
  logic [NODES-1:0] grp_g;
  logic [W:0]       c;

  cla_bit_pg #(.W(W)) u_pg (
    .a (a),
    .b (b),
    .p (grp_p[W-1:0]),
    .g (grp_g[W-1:0])
  );

  // Group tree: each node merges two adjacent nodes of the level below (R6).
  for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
    for (genvar m = 0; m < (W >> k); m++) begin : g_node
      localparam int CHILD  = level_base(W, k - 1) + 2 * m;
      localparam int PARENT = level_base(W, k) + m;
      cla_pg_merge u_merge (
        .lo_p (grp_p[CHILD]),
        .lo_g (grp_g[CHILD]),
        .hi_p (grp_p[CHILD + 1]),
        .hi_g (grp_g[CHILD + 1]),
        .p    (grp_p[PARENT]),
        .g    (grp_g[PARENT])
      );
    end
  end

  assign c[0] = cin;

  // Carry j uses the largest aligned group ending at bit j-1 and the carry
  // entering that group, which is a multiple of the group size (R3, R6).
  for (genvar j = 1; j <= W; j++) begin : g_carry
    localparam int T    = trail_zeros(j);
    localparam int SRC  = j - (1 << T);
    localparam int NODE = level_base(W, T) + (SRC >> T);
    cla_carry_step u_step (
      .grp_p (grp_p[NODE]),
      .grp_g (grp_g[NODE]),
      .ci    (c[SRC]),
      .co    (c[j])
    );
  end

  cla_sum #(.W(W)) u_sum (
    .p  (grp_p[W-1:0]),
    .ci (c[W-1:0]),
    .s  (sum)
  );

  assign cout = c[W];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic [W:0]   c
);
  logic [W:0] total;
  assign total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    p_total_r1: assert ({cout, sum} == total)
      else $error("R1 total mismatch");
    if ((a == '0) && !cin) begin
      p_zero_operand_r2: assert ((sum == b) && !cout)
        else $error("R2 zero operand mismatch");
    end
    if ((a ^ b) == {W{1'b1}}) begin
      p_full_propagate_r4: assert ((cout == cin) && (sum == {W{~cin}}))
        else $error("R4 propagate mismatch");
    end
    if (((a & b) == '0) && !cin) begin
      p_no_generate_r5: assert (!cout && (sum == (a | b)))
        else $error("R5 disjoint mismatch");
    end
  end

  for (genvar j = 1; j <= W; j++) begin : g_cj
    logic [j:0] low;
    assign low = {1'b0, a[j-1:0]} + {1'b0, b[j-1:0]} + {{j{1'b0}}, cin};
    always_comb begin
      p_carry_r3: assert (c[j] == low[j])
        else $error("R3 carry mismatch");
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.W(W)) u_chk (
  .a    (a),
  .b    (b),
  .cin  (cin),
  .sum  (sum),
  .cout (cout),
  .c    (c)
);

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
  localparam int W    = 8;
  localparam int NVEC = 1 << (2 * W + 1);

  logic         clk = 1'b0;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cla_adder #(.W(W)) dut (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               req, a, b, cin, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 190000) begin
      fails++;
      $display("FAIL watchdog (all R) actual=%0d expected<=%0d", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Idle state with all-zero inputs: zero result.
    @(negedge clk);
    check({cout, sum} == '0, "R1 idle", int'({cout, sum}), 0);

    for (int v = 0; v < NVEC; v++) begin
      @(posedge clk);
      a   <= v[W-1:0];
      b   <= v[2*W-1:W];
      cin <= v[2*W];
      @(negedge clk);
      begin
        int ea, eb, ec, exp_total, act_total;
        ea = int'(a); eb = int'(b); ec = int'(cin);
        exp_total = ea + eb + ec;
        act_total = int'({cout, sum});
        // R1: full arithmetic result
        check(act_total == exp_total, "R1", act_total, exp_total);
        // R3: carry into each bit, recovered at the ports
        for (int j = 1; j <= W; j++) begin
          int mask, exp_c, act_c;
          mask  = (1 << j) - 1;
          exp_c = (((ea & mask) + (eb & mask) + ec) >> j) & 1;
          act_c = (j == W) ? int'(cout) : int'(sum[j] ^ a[j] ^ b[j]);
          check(act_c == exp_c, "R3", act_c, exp_c);
        end
        // R6: carries taken from the group tree at 2, 4, 6, 8 and local steps
        if (ea == 0 && ec == 0)
          check(act_total == eb, "R2", act_total, eb);
        if ((ea ^ eb) == 255) begin
          int exp_p;
          exp_p = (ec << W) | (ec ? 0 : 255);
          check(act_total == exp_p, "R4", act_total, exp_p);
        end
        if ((ea & eb) == 0 && ec == 0)
          check(act_total == (ea | eb), "R5", act_total, ea | eb);
        if ((ea == 85 && eb == 170) || (ea == 255 && eb == 1))
          check(act_total == exp_total, "R6 long carry", act_total, exp_total);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule